// File: doc/BRIEF.md
# External Interrupt Edge Controller

The block turns level changes on external interrupt pins into sticky request flags, and a single global enable gates those flags onto one combined request line toward the processor. Two pins, plus a group of eight wake-up pins, raise their flags only on a high-to-low transition. Every wake-up pin sets the same shared flag. Two further pins each have a 2-bit detection mode, which selects no detection, falling edge, rising edge or both edges.

Each pin first passes through a synchronizer chain that resets to logic high. The block then compares the newest synchronized level against the level seen one cycle earlier. Software uses a small write port for three things: it loads the detection modes, it clears flags by writing zeros, and it sets a per-source unmask register. The processor pulses an accept strobe when it takes an interrupt, and this drops the global enable. A return strobe sets the enable again.

Top module: `xint_edge_ctrl`

## Requirements
- R1: After reset, all five flags read 0, the global enable reads 0, every source is masked, both detection modes are "no detection", and `irq_o` is 0.
- R2: A flag for a fixed pin (flag bit 0 for `fix_pin_i[0]`, bit 1 for `fix_pin_i[1]`) sets only on a falling edge. The flag reads 1 two rising clock edges after the first edge that samples the new low level. A rising edge leaves the flag unchanged.
- R3: A falling edge on any one of the eight `wake_pin_i` inputs sets flag bit 4. Simultaneous falls still produce a single flag. Rising edges have no effect.
- R4: Flag bits 2 and 3 follow `prog_pin_i[0]` and `prog_pin_i[1]` under 2-bit modes. Mode bits [1:0] govern `prog_pin_i[0]` and bits [3:2] govern `prog_pin_i[1]`. The codes are 00 no detection, 01 falling, 10 rising and 11 both edges. Detection latency is the same as in R2.
- R5: The mode register has no read path. It is loaded from `wr_data_i[3:0]` by a write with `wr_addr_i` = 0. A loaded mode applies to edges that are compared from the following cycle onward.
- R6: A write with `wr_addr_i` = 1 clears every flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. If a flag's set event falls in the same cycle as its clear, the flag ends at 1. Flags never clear on their own.
- R7: A write with `wr_addr_i` = 2 loads the unmask register from `wr_data_i[4:0]`, where bit i = 1 lets flag i reach `irq_o`. A write with `wr_addr_i` = 3 changes nothing.
- R8: `irq_o` is 1 exactly when the global enable is 1 and at least one flag is both pending and unmasked.
- R9: An `accept_i` pulse clears the global enable at the next clock edge. A `reti_i` pulse sets it. If both arrive together, the enable ends at 0. Otherwise the enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fix_pin_i | input | 2 | Falling-edge-only interrupt pins |
| prog_pin_i | input | 2 | Pins with programmable edge mode |
| wake_pin_i | input | 8 | Wake-up pins sharing one flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write target: 0 modes, 1 flag clear, 2 unmask, 3 none |
| wr_data_i | input | 5 | Write data |
| accept_i | input | 1 | Interrupt accepted, one-cycle pulse |
| reti_i | input | 1 | Return from interrupt, one-cycle pulse |
| flags_o | output | 5 | Pending request flags |
| gie_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that `accept_i` and `reti_i` are sampled only on clock edges. They also assume the pin inputs are free of glitches shorter than a cycle, so that every flag rise traces back to a detected edge in the previous cycle.

The stimulus drives every input at the falling clock edge and holds it for at least one full cycle. Flag writes, mode writes and strobes are issued both in isolation and, in a deliberate case, in the very cycle a set event lands. The pins are held high during reset, which matches the synchronizers' reset level.

// File: rtl/xint_pkg.sv
package xint_pkg;

  // 2-bit detection mode; the code values are part of the programming model
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // write port targets
  typedef enum logic [1:0] {
    WA_MODE  = 2'd0,
    WA_CLEAR = 2'd1,
    WA_MASK  = 2'd2,
    WA_SPARE = 2'd3
  } wr_addr_e;

  // decides whether a level step from prev to cur counts under a mode
  function automatic logic edge_hit(input edge_mode_e mode, input logic prev, input logic cur);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    case (mode)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  // enable update: acceptance dominates return
  function automatic logic gie_next(input logic cur, input logic accept, input logic reti);
    if (accept)    gie_next = 1'b0;
    else if (reti) gie_next = 1'b1;
    else           gie_next = cur;
  endfunction

endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // chain resets high: idle level of the pins, so release creates no edge
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/xint_edge_det.sv
module xint_edge_det
  import xint_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   lvl_i,
  input  logic [2*W-1:0] mode_i,
  output logic [W-1:0]   hit_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign hit_o[g] = edge_hit(edge_mode_e'(mode_i[2*g +: 2]), prev_q[g], lvl_i[g]);
  end

endmodule

// File: rtl/xint_flag_bank.sv
module xint_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] mask_o
);

  logic [N-1:0] flags_q;
  logic [N-1:0] mask_q;

  // set dominates a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;

endmodule

// File: rtl/xint_gate.sv
module xint_gate
  import xint_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic         reti_i,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  output logic         gie_o,
  output logic         irq_o
);

  logic gie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_next(gie_q, accept_i, reti_i);
  end

  assign gie_o = gie_q;
  assign irq_o = gie_q & (|(flags_i & mask_i));

endmodule

// File: rtl/xint_edge_ctrl.sv
module xint_edge_ctrl
  import xint_pkg::*;
#(
  parameter int unsigned N_FIX       = 2,
  parameter int unsigned N_PROG      = 2,
  parameter int unsigned WAKE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = ((N_FIX + N_PROG + 1) > 2 * N_PROG) ?
                                       (N_FIX + N_PROG + 1) : (2 * N_PROG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_FIX-1:0]        fix_pin_i,
  input  logic [N_PROG-1:0]       prog_pin_i,
  input  logic [WAKE_W-1:0]       wake_pin_i,
  input  logic                    wr_en_i,
  input  logic [1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic                    accept_i,
  input  logic                    reti_i,
  output logic [N_FIX+N_PROG:0]   flags_o,
  output logic                    gie_o,
  output logic                    irq_o
);

  localparam int unsigned NUM_SRC  = N_FIX + N_PROG + 1;
  localparam int unsigned CFG_W    = 2 * N_PROG;
  localparam int unsigned IDX_PROG = N_FIX;
  localparam int unsigned IDX_WAKE = N_FIX + N_PROG;
  localparam logic [2*N_FIX-1:0]  FIX_MODES  = {N_FIX{EDGE_FALL}};
  localparam logic [2*WAKE_W-1:0] WAKE_MODES = {WAKE_W{EDGE_FALL}};

  // synchronized pin levels
  logic [N_FIX-1:0]  fix_lvl;
  logic [N_PROG-1:0] prog_lvl;
  logic [WAKE_W-1:0] wake_lvl;

  // detected edge events, named for the checker
  logic [N_FIX-1:0]  fix_hit;
  logic [N_PROG-1:0] prog_hit;
  logic [WAKE_W-1:0] wake_hit;
  logic [NUM_SRC-1:0] flag_set;
  logic [NUM_SRC-1:0] flag_clr;

  // write decode
  wr_addr_e    addr;
  logic        mode_we;
  logic        mask_we;
  logic [CFG_W-1:0]   edge_cfg_q;
  logic [NUM_SRC-1:0] mask_q;

  assign addr    = wr_addr_e'(wr_addr_i);
  assign mode_we = wr_en_i && (addr == WA_MODE);
  assign mask_we = wr_en_i && (addr == WA_MASK);
  assign flag_clr = (wr_en_i && (addr == WA_CLEAR)) ? ~wr_data_i[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       edge_cfg_q <= '0;
    else if (mode_we) edge_cfg_q <= wr_data_i[CFG_W-1:0];
  end

  xint_sync #(.W(N_FIX), .STAGES(SYNC_STAGES)) u_sync_fix (
    .clk(clk), .rst_n(rst_n), .d_i(fix_pin_i), .q_o(fix_lvl)
  );
  xint_sync #(.W(N_PROG), .STAGES(SYNC_STAGES)) u_sync_prog (
    .clk(clk), .rst_n(rst_n), .d_i(prog_pin_i), .q_o(prog_lvl)
  );
  xint_sync #(.W(WAKE_W), .STAGES(SYNC_STAGES)) u_sync_wake (
    .clk(clk), .rst_n(rst_n), .d_i(wake_pin_i), .q_o(wake_lvl)
  );

  xint_edge_det #(.W(N_FIX)) u_det_fix (
    .clk(clk), .rst_n(rst_n), .lvl_i(fix_lvl), .mode_i(FIX_MODES), .hit_o(fix_hit)
  );
  xint_edge_det #(.W(N_PROG)) u_det_prog (
    .clk(clk), .rst_n(rst_n), .lvl_i(prog_lvl), .mode_i(edge_cfg_q), .hit_o(prog_hit)
  );
  xint_edge_det #(.W(WAKE_W)) u_det_wake (
    .clk(clk), .rst_n(rst_n), .lvl_i(wake_lvl), .mode_i(WAKE_MODES), .hit_o(wake_hit)
  );

  assign flag_set[N_FIX-1:0]            = fix_hit;
  assign flag_set[IDX_PROG +: N_PROG]   = prog_hit;
  assign flag_set[IDX_WAKE]             = |wake_hit;

  xint_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_i(flag_set), .clr_i(flag_clr),
    .mask_we_i(mask_we), .mask_d_i(wr_data_i[NUM_SRC-1:0]),
    .flags_o(flags_o), .mask_o(mask_q)
  );

  xint_gate #(.N(NUM_SRC)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .accept_i(accept_i), .reti_i(reti_i),
    .flags_i(flags_o), .mask_i(mask_q),
    .gie_o(gie_o), .irq_o(irq_o)
  );

endmodule

// File: rtl/xint_edge_ctrl_chk.sv
module xint_edge_ctrl_chk #(
  parameter int unsigned NUM_SRC  = 5,
  parameter int unsigned CFG_W    = 4,
  parameter int unsigned IDX_PROG = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               accept_i,
  input logic               reti_i,
  input logic               gie_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] flags_o,
  input logic [NUM_SRC-1:0] set_vec,
  input logic [NUM_SRC-1:0] mask_vec,
  input logic [CFG_W-1:0]   cfg_vec
);

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_o |-> !irq_o); // R8

  AST_IRQ_NEEDS_UNMASKED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((flags_o & mask_vec) != '0)); // R8

  AST_ACCEPT_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !gie_o); // R9

  AST_RETI_RAISES_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !accept_i) |=> gie_o); // R9

  AST_GIE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_i && !reti_i) |=> $stable(gie_o)); // R9

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags_o[i]); // R6

    AST_FLAG_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[i]) |-> $past(set_vec[i])); // R2
  end

  for (genvar j = 0; j < CFG_W / 2; j++) begin : g_prog
    AST_MODE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_vec[2*j +: 2] == 2'b00) |-> !set_vec[IDX_PROG + j]); // R4
  end

endmodule

bind xint_edge_ctrl xint_edge_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .CFG_W(CFG_W), .IDX_PROG(IDX_PROG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .reti_i(reti_i),
  .gie_o(gie_o), .irq_o(irq_o), .flags_o(flags_o),
  .set_vec(flag_set), .mask_vec(mask_q), .cfg_vec(edge_cfg_q)
);

// File: tb/xint_edge_ctrl_test.sv
`timescale 1ns/1ps
module xint_edge_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fix_pin = '1;
  logic [1:0] prog_pin = '1;
  logic [7:0] wake_pin = '1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic       accept = 1'b0;
  logic       reti = 1'b0;
  logic [4:0] flags;
  logic       gie;
  logic       irq;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  xint_edge_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .fix_pin_i(fix_pin), .prog_pin_i(prog_pin), .wake_pin_i(wake_pin),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .accept_i(accept), .reti_i(reti),
    .flags_o(flags), .gie_o(gie), .irq_o(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [11:0] hist[$];      // {wake, prog, fix}, newest first
  logic [4:0]  m_flags;
  logic [4:0]  m_mask;
  logic [3:0]  m_cfg;
  logic        m_gie;

  function automatic bit fires(input logic [1:0] md, input logic o, input logic n);
    bit fell;
    bit rose;
    fell = (o == 1'b1) && (n == 1'b0);
    rose = (o == 1'b0) && (n == 1'b1);
    if (md == 2'b01) return fell;
    if (md == 2'b10) return rose;
    if (md == 2'b11) return fell || rose;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    logic [11:0] o;
    logic [11:0] n;
    logic [4:0]  s;
    if (!rst_n) begin
      hist.delete();
      for (int k = 0; k < 4; k++) hist.push_back(12'hFFF);
      m_flags = '0;
      m_mask  = '0;
      m_cfg   = '0;
      m_gie   = 1'b0;
    end else begin
      hist.push_front({wake_pin, prog_pin, fix_pin});
      void'(hist.pop_back());
      o = hist[3];
      n = hist[2];
      s[0] = o[0] && !n[0];
      s[1] = o[1] && !n[1];
      s[2] = fires(m_cfg[1:0], o[2], n[2]);
      s[3] = fires(m_cfg[3:2], o[3], n[3]);
      s[4] = 1'b0;
      for (int w = 4; w < 12; w++) if (o[w] && !n[w]) s[4] = 1'b1;
      for (int b = 0; b < 5; b++) begin
        if (s[b]) m_flags[b] = 1'b1;
        else if (wr_en && wr_addr == 2'd1 && !wr_data[b]) m_flags[b] = 1'b0;
      end
      if (wr_en && wr_addr == 2'd0) m_cfg = wr_data[3:0];
      if (wr_en && wr_addr == 2'd2) m_mask = wr_data;
      if (accept) m_gie = 1'b0;
      else if (reti) m_gie = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "flags vs model", 32'(flags), 32'(m_flags));
      check(cur_req, "gie vs model", 32'(gie), 32'(m_gie));
      check(cur_req, "irq vs model", 32'(irq), 32'(m_gie && ((m_flags & m_mask) != 5'd0)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(input bit acc, input bit ret);
    @(negedge clk);
    accept = acc; reti = ret;
    @(negedge clk);
    accept = 1'b0; reti = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    cyc(3);
    check("R1", "flags in reset", 32'(flags), 32'd0);
    check("R1", "gie in reset", 32'(gie), 32'd0);
    check("R1", "irq in reset", 32'(irq), 32'd0);
    rst_n = 1'b1;
    cyc(3);

    // R9: global enable
    cur_req = "R9";
    strobe(1'b0, 1'b1);
    check("R9", "gie after reti", 32'(gie), 32'd1);
    strobe(1'b1, 1'b0);
    check("R9", "gie after accept", 32'(gie), 32'd0);
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b1);
    check("R9", "gie after accept+reti", 32'(gie), 32'd0);
    strobe(1'b0, 1'b1);

    // R7: unmask all sources
    cur_req = "R7";
    wr(2'd2, 5'b11111);
    check("R7", "irq with no flags", 32'(irq), 32'd0);

    // R2: fixed pin falling edge, latency, rising ignored
    cur_req = "R2";
    @(negedge clk); fix_pin[0] = 1'b0;
    cyc(2);
    check("R2", "flag0 one cycle early", 32'(flags[0]), 32'd0);
    cyc(1);
    check("R2", "flag0 after fall", 32'(flags[0]), 32'd1);
    check("R8", "irq with flag0", 32'(irq), 32'd1);
    wr(2'd1, 5'b11110);
    fix_pin[0] = 1'b1;
    cyc(4);
    check("R2", "flag0 after rise", 32'(flags[0]), 32'd0);

    // R6: write of 1 preserves, write of 0 clears
    cur_req = "R6";
    @(negedge clk); fix_pin[1] = 1'b0;
    @(negedge clk); fix_pin[0] = 1'b0;
    cyc(4);
    wr(2'd1, 5'b11110);
    check("R6", "flags after partial clear", 32'(flags), 32'b00010);
    fix_pin = 2'b11;
    wr(2'd1, 5'b00000);
    cyc(3);
    check("R6", "flags after full clear", 32'(flags), 32'd0);

    // R6: set in same cycle as clear wins
    @(negedge clk); fix_pin[1] = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd1; wr_data = 5'b11101;
    @(negedge clk); wr_en = 1'b0;
    check("R6", "set beats clear", 32'(flags[1]), 32'd1);
    fix_pin[1] = 1'b1;
    wr(2'd1, 5'b00000);

    // R3: wake-up group
    cur_req = "R3";
    @(negedge clk); wake_pin[5] = 1'b0;
    cyc(3);
    check("R3", "wake flag after fall", 32'(flags), 32'b10000);
    wr(2'd1, 5'b01111);
    wake_pin[5] = 1'b1;
    cyc(4);
    check("R3", "wake flag after rise", 32'(flags[4]), 32'd0);
    @(negedge clk); wake_pin = 8'b0110_0110;
    cyc(4);
    check("R3", "multiple wake falls", 32'(flags), 32'b10000);
    wake_pin = '1;
    wr(2'd1, 5'b00000);

    // R5: modes off after reset, prog pins silent
    cur_req = "R5";
    @(negedge clk); prog_pin = 2'b00;
    cyc(4);
    check("R5", "no detect falling at reset mode", 32'(flags[3:2]), 32'd0);
    prog_pin = 2'b11;
    cyc(4);
    check("R5", "no detect rising at reset mode", 32'(flags[3:2]), 32'd0);

    // R4: prog0 rising, prog1 both
    cur_req = "R4";
    wr(2'd0, 5'b01110);
    @(negedge clk); prog_pin = 2'b00;
    cyc(4);
    check("R4", "fall: only both-mode pin", 32'(flags[3:2]), 32'b10);
    wr(2'd1, 5'b00000);
    prog_pin = 2'b11;
    cyc(4);
    check("R4", "rise: rise and both", 32'(flags[3:2]), 32'b11);
    wr(2'd1, 5'b00000);
    wr(2'd0, 5'b00001);
    @(negedge clk); prog_pin = 2'b00;
    cyc(4);
    check("R4", "fall mode vs none", 32'(flags[3:2]), 32'b01);
    wr(2'd3, 5'b00000);
    check("R7", "spare address leaves flags", 32'(flags[3:2]), 32'b01);

    // R8/R7: masking and enable gating
    cur_req = "R8";
    wr(2'd2, 5'b11011);
    check("R7", "masked flag hides irq", 32'(irq), 32'd0);
    wr(2'd2, 5'b00100);
    check("R8", "unmasked flag raises irq", 32'(irq), 32'd1);
    strobe(1'b1, 1'b0);
    check("R8", "irq off when gie off", 32'(irq), 32'd0);
    prog_pin = 2'b11;
    wr(2'd1, 5'b00000);

    // mixed random traffic checked against the model every cycle
    cur_req = "R6";
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) fix_pin  = 2'($urandom);
      if ($urandom_range(0, 3) == 0) prog_pin = 2'($urandom);
      if ($urandom_range(0, 5) == 0) wake_pin = 8'($urandom) | 8'($urandom);
      wr_en   = ($urandom_range(0, 5) == 0);
      wr_addr = 2'($urandom);
      wr_data = 5'($urandom);
      accept  = ($urandom_range(0, 11) == 0);
      reti    = ($urandom_range(0, 5) == 0);
    end
    @(negedge clk);
    wr_en = 1'b0; accept = 1'b0; reti = 1'b0;
    cyc(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule